// File: doc/BRIEF.md
# Snoop-Aware Eviction Buffer

This block sits between a private write-back cache and a shared snooping bus. When the cache evicts a dirty line, it hands the line to this buffer and can fill the replacement line at once. The write to memory is deferred. The buffer writes its lines back to memory in the background, oldest first, whenever the bus is reported idle. The processor never waits on this drain.

While a line sits in the buffer, it is the only up-to-date copy outside the cache, so every entry can be searched. A local processor lookup that hits gets the buffered line and takes ownership of it back, which removes the entry. A snooped bus read that hits is answered in the same cycle with the buffered line, so the requester never sees the stale copy in memory. The entry is then dropped, because the flush that answers the snoop also updates memory. The entry whose memory write is in flight is locked: lookups still read it, but it leaves only when memory acknowledges the write.

Addresses on every port are line addresses, meaning the byte address with the line offset removed.

Top module: `evict_buffer`

## Requirements
- R1: After reset the buffer is empty: `push_ready` is 1, `mem_wr_req` is 0, and `cpu_hit` and `snp_hit` are 0.
- R2: In the cycle a snoop lookup matches a buffered line, `snp_hit` is 1 and `snp_data` carries that line's newest data. On a miss, or with no snoop request, `snp_hit` is 0.
- R3: A snoop hit on a line whose write is not in flight removes that line at the next clock edge. A repeated snoop to the same line then misses.
- R4: A processor lookup hit sets `cpu_hit` and returns the line in the same cycle, and it removes the entry unless that entry's write is in flight. A miss leaves every entry untouched.
- R5: When all 4 entries hold lines and no entry is freed in the cycle, `push_ready` is 0 for a new line address, and the eviction stalls.
- R6: A memory write starts (`mem_wr_req` rises) only in the cycle after one in which `bus_idle` was 1. Lines are written in the order they were first pushed. A removed entry does not count in this order.
- R7: While `mem_wr_req` is 1 and `mem_wr_ack` is 0, `mem_wr_tag` and `mem_wr_data` hold the same value. The head entry is freed at the edge on which `mem_wr_ack` is 1.
- R8: If a push and a write acknowledge arrive in the same cycle while the buffer is full, both complete. The buffer then holds 4 lines.
- R9: A push whose address matches a buffered line overwrites that entry's data in place. No second entry is made, and the entry keeps its place in the write order.
- R10: Lookups that hit the line being written return its data but leave it in the buffer. A push to that line address holds `push_ready` at 0 until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Dirty eviction offered |
| push_tag | input | 28 | Line address of the eviction |
| push_data | input | 128 | Line contents of the eviction |
| push_ready | output | 1 | Eviction accepted this cycle |
| cpu_req | input | 1 | Local processor lookup |
| cpu_tag | input | 28 | Line address looked up |
| cpu_hit | output | 1 | Lookup found a buffered line |
| cpu_data | output | 128 | Buffered line returned |
| snp_req | input | 1 | Snooped bus read lookup |
| snp_tag | input | 28 | Line address snooped |
| snp_hit | output | 1 | Snoop found a buffered line |
| snp_data | output | 128 | Buffered line driven to the bus |
| bus_idle | input | 1 | Bus free for a background write |
| mem_wr_req | output | 1 | Memory write pending |
| mem_wr_tag | output | 28 | Line address being written |
| mem_wr_data | output | 128 | Line data being written |
| mem_wr_ack | input | 1 | Memory accepted the write |

## Verification
On every cycle, the assertions check these properties:
- the in-flight write stays stable until its acknowledge;
- a write starts only after an idle bus cycle;
- a full buffer cannot grow;
- no line address is ever held twice;
- hit flags rise only with a request.

Some behaviours are visible only at the ports and over several cycles, so only the bench scenarios can show them. These are:
- drain order;
- removal of an entry after a snoop or processor hit;
- the in-place overwrite of a dirty line;
- the same-cycle push and acknowledge;
- the lock on the line being written.

// File: rtl/evict_buffer_pkg.sv
package evict_buffer_pkg;
    localparam int DEF_ENTRIES  = 4;
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_OFFSET_W = 4;
    localparam int DEF_LINE_W   = 128;
endpackage

// File: rtl/evict_buffer_match.sv
module evict_buffer_match #(
    parameter int N     = 4,
    parameter int TAG_W = 28
) (
    input  logic                      en,
    input  logic [TAG_W-1:0]          key,
    input  logic [N-1:0]              vld,
    input  logic [N-1:0][TAG_W-1:0]   tags,
    output logic [N-1:0]              hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en && vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/evict_buffer_store.sv
module evict_buffer_store #(
    parameter int N      = 4,
    parameter int TAG_W  = 28,
    parameter int LINE_W = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_valid,
    input  logic [TAG_W-1:0]          push_tag,
    input  logic [LINE_W-1:0]         push_data,
    output logic                      push_ready,
    input  logic [N-1:0]              cpu_hv,
    input  logic [N-1:0]              snp_hv,
    input  logic                      bus_idle,
    input  logic                      mem_wr_ack,
    output logic [N-1:0]              vld_o,
    output logic [N-1:0][TAG_W-1:0]   tag_o,
    output logic [N-1:0][LINE_W-1:0]  data_o,
    output logic                      busy_o
);
    typedef struct packed {
        logic [N-1:0]             vld;
        logic [N-1:0][TAG_W-1:0]  tag;
        logic [N-1:0][LINE_W-1:0] data;
        logic                     busy;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [N-1:0] rm;
    logic [N-1:0] phit;
    logic         blk;
    logic         rdy;

    always_comb begin
        int kept;
        st_d = st_q;
        rm   = '0;
        phit = '0;
        st_d.vld  = '0;
        st_d.tag  = '0;
        st_d.data = '0;
        kept = 0;
        // lookups free unlocked entries; an acknowledge frees the head
        for (int j = 0; j < N; j++) begin
            rm[j] = (cpu_hv[j] || snp_hv[j]) && !(st_q.busy && j == 0);
        end
        if (st_q.busy && mem_wr_ack) begin
            rm[0] = 1'b1;
        end
        // compact survivors toward slot 0, keeping their age order
        for (int j = 0; j < N; j++) begin
            if (st_q.vld[j] && !rm[j]) begin
                for (int i = 0; i < N; i++) begin
                    if (i == kept) begin
                        st_d.vld[i]  = 1'b1;
                        st_d.tag[i]  = st_q.tag[j];
                        st_d.data[i] = st_q.data[j];
                    end
                end
                kept++;
            end
        end
        for (int j = 0; j < N; j++) begin
            phit[j] = st_d.vld[j] && (st_d.tag[j] == push_tag);
        end
        blk = st_q.busy && !mem_wr_ack && st_q.vld[0] && (st_q.tag[0] == push_tag);
        rdy = !blk && ((kept < N) || (|phit));
        if (push_valid && rdy) begin
            if (|phit) begin
                for (int j = 0; j < N; j++) begin
                    if (phit[j]) begin
                        st_d.data[j] = push_data;
                    end
                end
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (i == kept) begin
                        st_d.vld[i]  = 1'b1;
                        st_d.tag[i]  = push_tag;
                        st_d.data[i] = push_data;
                    end
                end
            end
        end
        st_d.busy = (st_q.busy && !mem_wr_ack) ||
                    ((!st_q.busy || mem_wr_ack) && bus_idle && (|st_d.vld));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_ready = rdy;
    assign vld_o      = st_q.vld;
    assign tag_o      = st_q.tag;
    assign data_o     = st_q.data;
    assign busy_o     = st_q.busy;

    // R7
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !mem_wr_ack) |=>
        (st_q.busy && $stable(st_q.tag[0]) && $stable(st_q.data[0])));

    // R6
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(bus_idle));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.vld && !mem_wr_ack && cpu_hv == '0 && snp_hv == '0) |=> &st_q.vld);

    // R7
    head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.vld[0]);

    for (genvar a = 0; a < N; a++) begin : g_ua
        for (genvar b = a + 1; b < N; b++) begin : g_ub
            // R9
            uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(st_q.vld[a] && st_q.vld[b] && st_q.tag[a] == st_q.tag[b]));
        end
    end
endmodule

// File: rtl/evict_buffer.sv
module evict_buffer
    import evict_buffer_pkg::*;
#(
    parameter int ENTRIES  = DEF_ENTRIES,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int OFFSET_W = DEF_OFFSET_W,
    parameter int LINE_W   = DEF_LINE_W,
    localparam int TAG_W   = ADDR_W - OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [LINE_W-1:0] push_data,
    output logic              push_ready,
    input  logic              cpu_req,
    input  logic [TAG_W-1:0]  cpu_tag,
    output logic              cpu_hit,
    output logic [LINE_W-1:0] cpu_data,
    input  logic              snp_req,
    input  logic [TAG_W-1:0]  snp_tag,
    output logic              snp_hit,
    output logic [LINE_W-1:0] snp_data,
    input  logic              bus_idle,
    output logic              mem_wr_req,
    output logic [TAG_W-1:0]  mem_wr_tag,
    output logic [LINE_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    logic [ENTRIES-1:0]             vld;
    logic [ENTRIES-1:0][TAG_W-1:0]  tags;
    logic [ENTRIES-1:0][LINE_W-1:0] lines;
    logic [ENTRIES-1:0]             cpu_hv, snp_hv;
    logic                           busy;

    evict_buffer_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_cpu_cmp (
        .en(cpu_req), .key(cpu_tag), .vld(vld), .tags(tags), .hit(cpu_hv));

    evict_buffer_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_snp_cmp (
        .en(snp_req), .key(snp_tag), .vld(vld), .tags(tags), .hit(snp_hv));

    evict_buffer_store #(.N(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_tag(push_tag), .push_data(push_data),
        .push_ready(push_ready),
        .cpu_hv(cpu_hv), .snp_hv(snp_hv),
        .bus_idle(bus_idle), .mem_wr_ack(mem_wr_ack),
        .vld_o(vld), .tag_o(tags), .data_o(lines), .busy_o(busy));

    always_comb begin
        cpu_data = '0;
        snp_data = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (cpu_hv[j]) cpu_data = cpu_data | lines[j];
            if (snp_hv[j]) snp_data = snp_data | lines[j];
        end
    end

    assign cpu_hit     = |cpu_hv;
    assign snp_hit     = |snp_hv;
    assign mem_wr_req  = busy;
    assign mem_wr_tag  = tags[0];
    assign mem_wr_data = lines[0];

    // R2
    snp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |-> snp_req);

    // R4
    cpu_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> cpu_req);

    // R2
    snp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snp_hv));
endmodule

// File: tb/evict_buffer_test.sv
module evict_buffer_test;
    localparam int N = 4;
    localparam int TW = 28;
    localparam int LW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, cpu_req = 1'b0, snp_req = 1'b0;
    logic bus_idle = 1'b0, mem_wr_ack = 1'b0;
    logic [TW-1:0] push_tag = '0, cpu_tag = '0, snp_tag = '0;
    logic [LW-1:0] push_data = '0;
    logic push_ready, cpu_hit, snp_hit, mem_wr_req;
    logic [LW-1:0] cpu_data, snp_data, mem_wr_data;
    logic [TW-1:0] mem_wr_tag;

    always #2 clk = ~clk;

    evict_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_tag(push_tag), .push_data(push_data),
        .push_ready(push_ready),
        .cpu_req(cpu_req), .cpu_tag(cpu_tag), .cpu_hit(cpu_hit), .cpu_data(cpu_data),
        .snp_req(snp_req), .snp_tag(snp_tag), .snp_hit(snp_hit), .snp_data(snp_data),
        .bus_idle(bus_idle),
        .mem_wr_req(mem_wr_req), .mem_wr_tag(mem_wr_tag), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack));

    int checks = 0;
    int fails = 0;
    string scen = "R1";
    logic [TW-1:0] mq_t[$];
    logic [LW-1:0] mq_d[$];
    bit m_busy = 0;

    function automatic logic [LW-1:0] mkd(input logic [TW-1:0] t, input logic [7:0] s);
        return {4{{4'h0, t} ^ {24'h0, s}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, scen, act, exp);
        end
    endtask

    task automatic idle_in();
        push_valid = 0; cpu_req = 0; snp_req = 0; mem_wr_ack = 0;
    endtask

    // drive at negedge, compare 1 ns later, advance model at posedge
    task automatic tick();
        int ci, si, ph;
        bit rmv[N];
        bit blk, rdy, nb;
        logic [TW-1:0] nt[$];
        logic [LW-1:0] nd[$];
        #1;
        ci = -1; si = -1; ph = -1;
        for (int i = 0; i < mq_t.size(); i++) begin
            if (cpu_req && mq_t[i] == cpu_tag) ci = i;
            if (snp_req && mq_t[i] == snp_tag) si = i;
        end
        chk(cpu_hit == (ci >= 0), "R4", LW'(cpu_hit), LW'(ci >= 0));
        if (ci >= 0) chk(cpu_data == mq_d[ci], "R4", cpu_data, mq_d[ci]);
        chk(snp_hit == (si >= 0), "R2", LW'(snp_hit), LW'(si >= 0));
        if (si >= 0) chk(snp_data == mq_d[si], "R2", snp_data, mq_d[si]);
        chk(mem_wr_req == m_busy, "R6", LW'(mem_wr_req), LW'(m_busy));
        if (m_busy) begin
            chk(mem_wr_tag == mq_t[0], "R6", LW'(mem_wr_tag), LW'(mq_t[0]));
            chk(mem_wr_data == mq_d[0], "R7", mem_wr_data, mq_d[0]);
        end
        for (int i = 0; i < N; i++) begin
            rmv[i] = ((i == ci) || (i == si)) && !(m_busy && i == 0);
        end
        if (m_busy && mem_wr_ack) rmv[0] = 1;
        for (int i = 0; i < mq_t.size(); i++) begin
            if (!rmv[i]) begin
                nt.push_back(mq_t[i]);
                nd.push_back(mq_d[i]);
            end
        end
        blk = m_busy && !mem_wr_ack && mq_t.size() > 0 && mq_t[0] == push_tag;
        for (int i = 0; i < nt.size(); i++) if (nt[i] == push_tag) ph = i;
        rdy = !blk && (nt.size() < N || ph >= 0);
        chk(push_ready == rdy, "R5", LW'(push_ready), LW'(rdy));
        if (push_valid && rdy) begin
            if (ph >= 0) nd[ph] = push_data;
            else begin
                nt.push_back(push_tag);
                nd.push_back(push_data);
            end
        end
        nb = (m_busy && !mem_wr_ack) || ((!m_busy || mem_wr_ack) && bus_idle && nt.size() > 0);
        @(posedge clk);
        mq_t = nt;
        mq_d = nd;
        m_busy = nb;
        @(negedge clk);
        idle_in();
    endtask

    task automatic push(input logic [TW-1:0] t, input logic [7:0] s);
        push_valid = 1; push_tag = t; push_data = mkd(t, s);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        scen = "R1";
        chk(push_ready == 1'b1, "R1", LW'(push_ready), LW'(1));
        chk(mem_wr_req == 1'b0, "R1", LW'(mem_wr_req), LW'(0));
        chk(!cpu_hit && !snp_hit, "R1", LW'({cpu_hit, snp_hit}), LW'(0));
        @(negedge clk);

        bus_idle = 0;
        scen = "R1";
        push(28'h10, 8'h01); tick();
        push(28'h11, 8'h02); tick();
        push(28'h12, 8'h03); tick();
        push(28'h13, 8'h04); tick();
        scen = "R5";
        push(28'h14, 8'h05); #1;
        chk(push_ready == 1'b0, "R5", LW'(push_ready), LW'(0));
        tick();

        scen = "R3";
        snp_req = 1; snp_tag = 28'h11; tick();
        snp_req = 1; snp_tag = 28'h11; #1;
        chk(snp_hit == 1'b0, "R3", LW'(snp_hit), LW'(0));
        tick();
        scen = "R4";
        cpu_req = 1; cpu_tag = 28'h20; tick();
        cpu_req = 1; cpu_tag = 28'h12; tick();
        cpu_req = 1; cpu_tag = 28'h12; tick();

        scen = "R9";
        push(28'h10, 8'hA5); tick();
        push(28'h14, 8'h06); tick();
        push(28'h15, 8'h07); tick();

        scen = "R6";
        bus_idle = 1; tick();
        bus_idle = 0;
        #1;
        chk(mem_wr_data == mkd(28'h10, 8'hA5), "R9", mem_wr_data, mkd(28'h10, 8'hA5));
        scen = "R7";
        tick(); tick();
        scen = "R10";
        snp_req = 1; snp_tag = 28'h10; tick();
        cpu_req = 1; cpu_tag = 28'h10; tick();
        push(28'h10, 8'hB6); #1;
        chk(push_ready == 1'b0, "R10", LW'(push_ready), LW'(0));
        tick();
        scen = "R8";
        push(28'h16, 8'h08); mem_wr_ack = 1; #1;
        chk(push_ready == 1'b1, "R8", LW'(push_ready), LW'(1));
        tick();
        push(28'h17, 8'h09); #1;
        chk(push_ready == 1'b0, "R8", LW'(push_ready), LW'(0));
        tick();

        scen = "R6";
        bus_idle = 1;
        for (int k = 0; k < 16; k++) begin
            mem_wr_ack = m_busy && (k % 2 == 1);
            tick();
        end
        #1;
        chk(mem_wr_req == 1'b0, "R6", LW'(mem_wr_req), LW'(0));
        @(negedge clk);

        scen = "R4 R2 R9 mixed";
        for (int k = 0; k < 400; k++) begin
            bus_idle = ($urandom % 3) == 0;
            if ($urandom % 2) push(TW'($urandom % 6), 8'($urandom));
            if ($urandom % 4 == 0) begin cpu_req = 1; cpu_tag = TW'($urandom % 6); end
            if ($urandom % 4 == 0) begin snp_req = 1; snp_tag = TW'($urandom % 6); end
            mem_wr_ack = m_busy && ($urandom % 3 == 0);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule